// File: doc/BRIEF.md
# Supply and Watchdog Reset Sequencer

This block is the digital core of a processor supervisor. It takes a low-supply flag from an external comparator, a heartbeat line toggled by software, and a slow timebase tick, and it produces the processor reset in both polarities. It also produces a watchdog-fault flag and a gated chip-enable that keeps memory deselected while reset is active. All timing is counted in timebase ticks, so that a fast system clock can drive slow supervision intervals.

A reset begins when the supply flag goes active or when the heartbeat stops toggling for longer than the watchdog limit. In both cases reset is held for a fixed number of ticks after the cause clears. The watchdog limit is either short or long, chosen by a select input. The first watchdog period after any reset release is always the long one, which gives boot code time to start toggling the heartbeat.

Top module: `sup_reset_sequencer`

## Requirements
- R1: While `supply_low_n` is 0, `rst_out_n` is 0 from the next clock on. After `supply_low_n` returns to 1, `rst_out_n` stays 0 until HOLD_TICKS ticks have been seen, and rises on the clock that takes the last of them.
- R2: `hb_in` passes through two synchronizing flops. Every change of its synchronized level, rising or falling, restarts the watchdog count from zero, and a change that lasts a single clock counts as one transition.
- R3: With the watchdog running and no heartbeat transition, reaching the watchdog limit in ticks drives `rst_out_n` and `wd_fault_n` to 0 on the same clock.
- R4: After the first heartbeat transition following a reset release, the limit is SHORT_TICKS when `wd_sel_long` is 0 and LONG_TICKS when it is 1.
- R5: From a reset release until the first heartbeat transition, the limit is LONG_TICKS whatever `wd_sel_long` says.
- R6: A watchdog timeout holds reset for exactly HOLD_TICKS ticks, then releases it.
- R7: While `wd_en` is 0 the watchdog count is held at zero and no watchdog timeout or fault occurs.
- R8: `rst_out` is always the inverse of `rst_out_n`.
- R9: `ce_out_n` equals `ce_in_n` while `rst_out_n` is 1, and is 1 while `rst_out_n` is 0.
- R10: `wd_fault_n` returns to 1 on the clock after a heartbeat transition or after `supply_low_n` is seen at 0, and it never falls while reset is already asserted.
- R11: While `arst_n` is 0, `rst_out_n` is 0, `rst_out` is 1, `wd_fault_n` is 1 and `ce_out_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous power-on clear, active low |
| tick | input | 1 | One-clock timebase pulse that advances all counts |
| supply_low_n | input | 1 | Comparator flag, 0 when the supply is low |
| hb_in | input | 1 | Processor heartbeat, asynchronous |
| wd_en | input | 1 | 1 enables the watchdog |
| wd_sel_long | input | 1 | 1 selects the long watchdog limit |
| ce_in_n | input | 1 | Chip-enable request, active low |
| rst_out_n | output | 1 | Processor reset, active low |
| rst_out | output | 1 | Processor reset, active high |
| wd_fault_n | output | 1 | Watchdog fault flag, active low |
| ce_out_n | output | 1 | Gated chip-enable, active low |

## Verification
The hardest situation to reach is a timeout that ends the long first period with the select input asking for the short limit. That needs a clean reset release, a heartbeat held perfectly still and a known tick rate all at once. A directed sequence pulses the supply flag, then holds the heartbeat with a tick on every clock, and counts the high cycles of reset against the long limit and then the low cycles against the hold length. Random phases with heartbeat gaps spread around both limits, short supply dips and watchdog-enable flips are checked cycle by cycle against a bench model of the timing.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // Watchdog limit in ticks for the current period.
  function automatic int wd_limit(input logic first_period, input logic sel_long,
                                  input int short_ticks, input int long_ticks);
    return (first_period || sel_long) ? long_ticks : short_ticks;
  endfunction

  // Counter width able to hold the largest of the limits.
  function automatic int count_bits(input int a, input int b);
    return $clog2(((a > b) ? a : b) + 1);
  endfunction

endpackage

// File: rtl/sup_hb_edge.sv
module sup_hb_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic hb_in,
  output logic hb_edge
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] pipe;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe <= '0;
    else         pipe <= {pipe[PIPE_W-2:0], hb_in};
  end

  // The last synchronizer stage against its delayed copy.
  assign hb_edge = pipe[PIPE_W-1] ^ pipe[PIPE_W-2];
endmodule

// File: rtl/sup_wd_timer.sv
module sup_wd_timer #(
  parameter int SHORT_TICKS = 5,
  parameter int LONG_TICKS  = 12,
  parameter int CNT_W       = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick,
  input  logic hold_clear,
  input  logic wd_en,
  input  logic sel_long,
  input  logic hb_edge,
  output logic timeout,
  output logic first_period
);
  logic [CNT_W-1:0] cnt;
  int               limit;
  logic             at_limit;

  assign limit    = sup_pkg::wd_limit(first_period, sel_long, SHORT_TICKS, LONG_TICKS);
  assign at_limit = (int'(cnt) == limit - 1);
  assign timeout  = !hold_clear && wd_en && tick && !hb_edge && at_limit;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt          <= '0;
      first_period <= 1'b1;
    end else if (hold_clear) begin
      cnt          <= '0;
      first_period <= 1'b1;
    end else if (!wd_en) begin
      cnt <= '0;
    end else if (hb_edge) begin
      cnt          <= '0;
      first_period <= 1'b0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sup_rst_hold.sv
module sup_rst_hold #(
  parameter int HOLD_TICKS = 7,
  parameter int CNT_W      = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick,
  input  logic supply_low_n,
  input  logic wd_timeout,
  output logic in_reset,
  output logic hold_done
);
  logic [CNT_W-1:0] cnt;
  logic             start;

  assign start     = !supply_low_n || wd_timeout;
  assign hold_done = in_reset && tick && !start && (int'(cnt) == HOLD_TICKS - 1);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      in_reset <= 1'b1;
      cnt      <= '0;
    end else if (start) begin
      in_reset <= 1'b1;
      cnt      <= '0;
    end else if (hold_done) begin
      in_reset <= 1'b0;
      cnt      <= '0;
    end else if (in_reset && tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sup_reset_sequencer.sv
module sup_reset_sequencer #(
  parameter int SHORT_TICKS = 5,
  parameter int LONG_TICKS  = 12,
  parameter int HOLD_TICKS  = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick,
  input  logic supply_low_n,
  input  logic hb_in,
  input  logic wd_en,
  input  logic wd_sel_long,
  input  logic ce_in_n,
  output logic rst_out_n,
  output logic rst_out,
  output logic wd_fault_n,
  output logic ce_out_n
);
  localparam int CNT_W = sup_pkg::count_bits(LONG_TICKS, HOLD_TICKS);

  logic hb_edge;
  logic wd_timeout;
  logic first_period;
  logic in_reset;
  logic hold_done;

  sup_hb_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .arst_n(arst_n), .hb_in(hb_in), .hb_edge(hb_edge)
  );

  sup_wd_timer #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS), .CNT_W(CNT_W)) u_wd (
    .clk(clk), .arst_n(arst_n), .tick(tick), .hold_clear(in_reset), .wd_en(wd_en),
    .sel_long(wd_sel_long), .hb_edge(hb_edge), .timeout(wd_timeout),
    .first_period(first_period)
  );

  sup_rst_hold #(.HOLD_TICKS(HOLD_TICKS), .CNT_W(CNT_W)) u_hold (
    .clk(clk), .arst_n(arst_n), .tick(tick), .supply_low_n(supply_low_n),
    .wd_timeout(wd_timeout), .in_reset(in_reset), .hold_done(hold_done)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)            wd_fault_n <= 1'b1;
    else if (!supply_low_n) wd_fault_n <= 1'b1;
    else if (wd_timeout)    wd_fault_n <= 1'b0;
    else if (hb_edge)       wd_fault_n <= 1'b1;
  end

  assign rst_out_n = !in_reset;
  assign rst_out   = in_reset;
  assign ce_out_n  = in_reset ? 1'b1 : ce_in_n;
endmodule

// File: rtl/sup_reset_sequencer_chk.sv
module sup_reset_sequencer_chk (
  input logic clk,
  input logic arst_n,
  input logic tick,
  input logic supply_low_n,
  input logic wd_en,
  input logic rst_out_n,
  input logic rst_out,
  input logic wd_fault_n,
  input logic ce_out_n,
  input logic wd_timeout,
  input logic hold_done
);
  assert_rst_pair_R8: assert property (@(posedge clk) disable iff (!arst_n)
    rst_out == !rst_out_n);

  assert_ce_blocked_R9: assert property (@(posedge clk) disable iff (!arst_n)
    !rst_out_n |-> ce_out_n);

  assert_supply_holds_R1: assert property (@(posedge clk) disable iff (!arst_n)
    !supply_low_n |=> !rst_out_n);

  assert_supply_clears_fault_R10: assert property (@(posedge clk) disable iff (!arst_n)
    !supply_low_n |=> wd_fault_n);

  assert_timeout_effect_R3: assert property (@(posedge clk) disable iff (!arst_n)
    wd_timeout |=> (!rst_out_n && !wd_fault_n));

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!arst_n)
    !wd_en |-> !wd_timeout);

  assert_release_on_tick_R6: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_out_n) |-> $past(tick) && $past(hold_done));

  assert_no_fault_in_reset_R10: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(wd_fault_n) |-> $past(rst_out_n));
endmodule

bind sup_reset_sequencer sup_reset_sequencer_chk u_chk (
  .clk(clk), .arst_n(arst_n), .tick(tick), .supply_low_n(supply_low_n), .wd_en(wd_en),
  .rst_out_n(rst_out_n), .rst_out(rst_out), .wd_fault_n(wd_fault_n), .ce_out_n(ce_out_n),
  .wd_timeout(wd_timeout), .hold_done(hold_done)
);

// File: tb/sup_reset_sequencer_test.sv
module sup_reset_sequencer_test;
  localparam int SHORT = 5;
  localparam int LONG  = 12;
  localparam int HOLD  = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic arst_n, tick, supply_low_n, hb_in, wd_en, wd_sel_long, ce_in_n;
  logic rst_out_n, rst_out, wd_fault_n, ce_out_n;

  sup_reset_sequencer #(.SHORT_TICKS(SHORT), .LONG_TICKS(LONG), .HOLD_TICKS(HOLD)) uut (
    .clk(clk), .arst_n(arst_n), .tick(tick), .supply_low_n(supply_low_n), .hb_in(hb_in),
    .wd_en(wd_en), .wd_sel_long(wd_sel_long), .ce_in_n(ce_in_n),
    .rst_out_n(rst_out_n), .rst_out(rst_out), .wd_fault_n(wd_fault_n), .ce_out_n(ce_out_n)
  );

  int    checks = 0;
  int    fails  = 0;
  string phase_req = "R11";
  logic  s_rn, s_fn;

  // Reference timing model, kept in ticks elapsed and ticks left.
  logic m_h1, m_h2, m_h3;
  logic m_run, m_long, m_fault_ok;
  int   m_left, m_elapsed;
  wire  m_edge = m_h2 ^ m_h3;

  function automatic int exp_limit(input logic longp, input logic sel);
    if (longp) return LONG;
    return sel ? LONG : SHORT;
  endfunction

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_h1 <= 0; m_h2 <= 0; m_h3 <= 0;
      m_run <= 0; m_left <= HOLD; m_elapsed <= 0; m_long <= 1; m_fault_ok <= 1;
    end else begin
      m_h1 <= hb_in; m_h2 <= m_h1; m_h3 <= m_h2;
      if (m_edge) m_fault_ok <= 1;
      if (!supply_low_n) begin
        m_run <= 0; m_left <= HOLD; m_elapsed <= 0; m_long <= 1; m_fault_ok <= 1;
      end else if (!m_run) begin
        m_elapsed <= 0; m_long <= 1;
        if (tick) begin
          if (m_left == 1) begin m_run <= 1; m_left <= HOLD; end
          else m_left <= m_left - 1;
        end
      end else if (!wd_en) begin
        m_elapsed <= 0;
      end else if (m_edge) begin
        m_elapsed <= 0; m_long <= 0;
      end else if (tick) begin
        if (m_elapsed + 1 == exp_limit(m_long, wd_sel_long)) begin
          m_run <= 0; m_left <= HOLD; m_elapsed <= 0; m_fault_ok <= 0;
        end else m_elapsed <= m_elapsed + 1;
      end
    end
  end

  task automatic check1(input string name, input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, name, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check1("rst_out_n", phase_req, rst_out_n, m_run);
    check1("rst_out", "R8", rst_out, !m_run);
    check1("ce_out_n", "R9", ce_out_n, m_run ? ce_in_n : 1'b1);
    check1("wd_fault_n", "R10", wd_fault_n, m_fault_ok);
  endtask

  task automatic step(input logic tk, input logic hb, input logic sup,
                      input logic en, input logic sel, input logic ce);
    @(negedge clk);
    check_all();
    s_rn = rst_out_n;
    s_fn = wd_fault_n;
    tick = tk; hb_in = hb; supply_low_n = sup; wd_en = en; wd_sel_long = sel; ce_in_n = ce;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (all requirements): got hung run expected completion");
    summary();
    $finish;
  end

  initial begin
    int n;
    logic hb;
    void'($urandom(32'd24681));
    arst_n = 0; tick = 0; supply_low_n = 1; hb_in = 0; wd_en = 1; wd_sel_long = 0; ce_in_n = 0;
    repeat (3) @(negedge clk);
    // R11: power-on clear state
    check1("rst_out_n", "R11", rst_out_n, 1'b0);
    check1("rst_out", "R11", rst_out, 1'b1);
    check1("wd_fault_n", "R11", wd_fault_n, 1'b1);
    check1("ce_out_n", "R11", ce_out_n, 1'b1);
    arst_n = 1;

    // R5 and R6: long first period with short selected, then hold length
    phase_req = "R5";
    hb = 0;
    repeat (2) step(1, hb, 0, 1, 0, 0);
    n = 0;
    do begin step(1, hb, 1, 1, 0, 0); n++; end while (s_rn == 0 && n < 100);
    n = 1;
    while (n < 200) begin
      step(1, hb, 1, 1, 0, 0);
      if (s_rn == 1) n++; else break;
    end
    check1("high cycles before timeout", "R5", (n == LONG), 1'b1);
    if (n != LONG) $display("FAIL R5 first period: got %0d expected %0d", n, LONG);
    check1("fault at timeout", "R3", s_fn, 1'b0);
    phase_req = "R6";
    n = 1;
    while (n < 200) begin
      step(1, hb, 1, 1, 0, 0);
      if (s_rn == 0) n++; else break;
    end
    check1("low cycles after timeout", "R6", (n == HOLD), 1'b1);
    if (n != HOLD) $display("FAIL R6 hold length: got %0d expected %0d", n, HOLD);

    // R7: disabled watchdog never trips
    phase_req = "R7";
    n = 0;
    for (int i = 0; i < 3 * LONG; i++) begin
      step(1, hb, 1, 0, 0, 1);
      if (s_rn == 0) n++;
    end
    check1("reset while disabled", "R7", (n == 0), 1'b1);

    // Random phases checked against the model every cycle
    for (int p = 0; p < 12; p++) begin
      logic sel;
      int   hb_div;
      case (p % 4)
        0: begin phase_req = "R1"; hb_div = 4;  end
        1: begin phase_req = "R2"; hb_div = 3;  end
        2: begin phase_req = "R3"; hb_div = 20; end
        default: begin phase_req = "R4"; hb_div = 10; end
      endcase
      sel = 1'($urandom % 2);
      for (int c = 0; c < 300; c++) begin
        logic sup, en;
        if (($urandom % hb_div) == 0) hb = ~hb;
        sup = (p % 4 == 0) ? (($urandom % 40) != 0) : 1'b1;
        en  = (p % 4 == 1) ? (($urandom % 16) != 0) : 1'b1;
        step(1'($urandom % 2), hb, sup, en, sel, 1'($urandom % 2));
      end
    end

    step(0, hb, 1, 1, 0, 0);
    summary();
    $finish;
  end
endmodule